// File: doc/BRIEF.md
# Clock-Edge Phase Modulation Encoder

This block sends a serial bit stream over one forwarded clock line. The clock keeps running at a steady rate, and each data bit shows up only as the position of the falling edge inside its clock period. The block runs on a slot clock with several slots per bit period (four by default). Each bit period opens with a high slot, so a rising edge starts every period. The line then falls early for a zero and late for a one. In hardware, the slot stream would feed DDR output registers clocked at half the slot rate. This model is a single synchronous slot-clock domain.

Data enters one bit at a time through a valid/ready handshake. The encoder accepts a bit only at a bit boundary. If no bit is offered at that point, it sends a zero period so the line clock never stops. A strobe marks the first slot of every bit period on the line.

Top module: `edgephase_enc`

## Requirements
- R1: During synchronous active-low reset and in the first cycle after it, `line_out` is 1, `bit_start` is 1 and `in_ready` is 0. The line starts in slot 0 of an idle (zero) bit.
- R2: `in_ready` is high for exactly one cycle in every four: the last slot of each bit period, where the slot counter wraps to slot 0.
- R3: An accepted zero produces the line pattern 1,0,0,0 over the four slots after the accepting edge.
- R4: An accepted one produces the line pattern 1,1,1,0 over the four slots after the accepting edge.
- R5: Every bit period starts with the line high and `bit_start` high, and ends with the line low in its last slot. This puts a rising edge every four cycles whatever the data.
- R6: If `in_valid` is low at a bit boundary, the next period carries the zero pattern 1,0,0,0.
- R7: `in_valid` and `in_data` have no effect while `in_ready` is low. The line is driven from a register, so input changes inside a period never alter that period.
- R8: The input bits 1,0,1,1,0 produce the line sequence 1110 1000 1110 1110 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A data bit is offered |
| in_data | input | 1 | Data bit value |
| in_ready | output | 1 | High in the last slot; the bit is taken on this edge |
| line_out | output | 1 | Registered line level for the current slot |
| bit_start | output | 1 | High in slot 0 of each bit period |

## Verification
The hardest case to reach is input that is valid but arrives mid-period. A correct design must ignore it, and the line gives no sign that it was ignored unless the effect is looked for in the following period. The stimulus holds `in_valid` high with a one on `in_data` through slots 0 to 2 of a zero period. It then withdraws the bit exactly in the ready slot. The bench expects that period and the next to both show the zero pattern.

// File: rtl/edgephase_pkg.sv
// Package: shared constants and the slot-to-level mapping for the encoder.
// Assumes slots are numbered from 0 at the start of each bit period.
package edgephase_pkg;
    localparam int DEF_SLOTS     = 4;
    localparam int DEF_ZERO_HIGH = 1;
    localparam int DEF_ONE_HIGH  = 3;

    // Line level for one slot: high while the slot index is below the bit's high count.
    function automatic logic slot_level(input logic data_bit, input int slot,
                                        input int zero_high, input int one_high);
        int high_cnt;
        high_cnt = data_bit ? one_high : zero_high;
        return (slot < high_cnt);
    endfunction
endpackage

// File: rtl/edgephase_slot_ctr.sv
// Slot counter: counts slots inside one bit period and flags the wrap slot.
// Assumes SLOTS >= 2; reset puts the counter on slot 0.
module edgephase_slot_ctr #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              wrap
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    // Wrap flag and the following slot index.
    always_comb begin
        wrap     = (slot_q == LAST);
        slot_nxt = wrap ? '0 : slot_q + 1'b1;
    end

    // Slot register.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_nxt;
    end

    // A wrap slot is never followed directly by another wrap slot.
    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !wrap);
endmodule

// File: rtl/edgephase_bit_reg.sv
// Bit holder: takes the offered bit at a boundary, or a zero when none is valid.
// Assumes take is high only in the wrap slot; the bit is held for the whole period.
module edgephase_bit_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic in_valid,
    input  logic in_data,
    output logic bit_nxt
);
    logic bit_q;

    // Next bit: new data or idle zero at a boundary, else hold.
    always_comb begin
        bit_nxt = take ? (in_valid & in_data) : bit_q;
    end

    // Bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_nxt;
    end

    // Off the boundary, the inputs cannot change the held bit.
    assert_hold_off_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(bit_q));
endmodule

// File: rtl/edgephase_line_gen.sv
// Line generator: registers the line level and the period-start strobe.
// Assumes slot_nxt/bit_nxt describe the slot that the next edge enters.
module edgephase_line_gen #(
    parameter int SLOT_W    = 2,
    parameter int ZERO_HIGH = 1,
    parameter int ONE_HIGH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_nxt,
    input  logic              bit_nxt,
    output logic              line_q,
    output logic              strobe_q
);
    import edgephase_pkg::*;

    logic line_d;

    // Level of the slot about to start.
    always_comb begin
        line_d = slot_level(bit_nxt, int'(slot_nxt), ZERO_HIGH, ONE_HIGH);
    end

    // Output registers; reset shows slot 0 of an idle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= 1'b1;
            strobe_q <= 1'b1;
        end else begin
            line_q   <= line_d;
            strobe_q <= (slot_nxt == '0);
        end
    end

    // Every period opens high.
    assert_start_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> line_q);
endmodule

// File: rtl/edgephase_enc.sv
// Top: falling-edge phase modulation encoder on a slot clock.
// Assumes one clock domain; the bit is accepted on the edge that ends the ready slot.
module edgephase_enc #(
    parameter int SLOTS     = edgephase_pkg::DEF_SLOTS,
    parameter int ZERO_HIGH = edgephase_pkg::DEF_ZERO_HIGH,
    parameter int ONE_HIGH  = edgephase_pkg::DEF_ONE_HIGH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_data,
    output logic in_ready,
    output logic line_out,
    output logic bit_start
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;
    logic              wrap;
    logic              bit_nxt;

    edgephase_slot_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .slot_nxt(slot_nxt), .wrap(wrap));

    edgephase_bit_reg u_bit (
        .clk(clk), .rst_n(rst_n), .take(wrap), .in_valid(in_valid),
        .in_data(in_data), .bit_nxt(bit_nxt));

    edgephase_line_gen #(.SLOT_W(SLOT_W), .ZERO_HIGH(ZERO_HIGH), .ONE_HIGH(ONE_HIGH)) u_line (
        .clk(clk), .rst_n(rst_n), .slot_nxt(slot_nxt), .bit_nxt(bit_nxt),
        .line_q(line_out), .strobe_q(bit_start));

    // Ready flags the last slot of the period.
    always_comb begin
        in_ready = wrap;
    end

    // Last slot of every period is low, so the next period gives a rising edge.
    assert_last_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !line_out);
    // Ready is never shown in the period's first slot.
    assert_no_ready_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> !in_ready || (slot_q != '0));
endmodule

// File: tb/edgephase_enc_tb.sv
module edgephase_enc_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_data = 1'b0;
    logic in_ready, line_out, bit_start;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edgephase_enc dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .line_out(line_out), .bit_start(bit_start));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Wait for the ready slot (at a negedge), offer a bit, collect 4 slots.
    task automatic send_bit(input logic v, input logic d, output logic [3:0] pat,
                            output logic [3:0] strb);
        int n = 0;
        while (!in_ready && n < 8) begin @(negedge clk); n++; end
        in_valid = v; in_data = d;
        @(negedge clk);
        in_valid = 1'b0; in_data = 1'b0;
        for (int s = 0; s < 4; s++) begin
            pat[3-s] = line_out; strb[3-s] = bit_start;
            if (s < 3) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 line", {7'd0, line_out}, 8'd1);
        check("R1 strobe", {7'd0, bit_start}, 8'd1);
        check("R1 ready", {7'd0, in_ready}, 8'd0);
        rst_n = 1'b1;
        check("R1 first cycle line", {7'd0, line_out}, 8'd1);
    endtask

    task automatic t_ready_period();
        int cnt = 0;
        for (int i = 0; i < 16; i++) begin @(negedge clk); cnt += int'(in_ready); end
        check("R2 ready count in 16", 8'(cnt), 8'd4);
    endtask

    task automatic t_single(input logic d, input string req);
        logic [3:0] p, s;
        send_bit(1'b1, d, p, s);
        check(req, {4'd0, p}, d ? 8'b1110 : 8'b1000);
        check("R5 strobe slot0 only", {4'd0, s}, 8'b1000);
    endtask

    task automatic t_idle();
        logic [3:0] p, s;
        send_bit(1'b0, 1'b1, p, s);
        check("R6 idle pattern", {4'd0, p}, 8'b1000);
    endtask

    task automatic t_sequence();
        logic [3:0] p, s;
        logic [19:0] got;
        logic [4:0] bits = 5'b10110;
        for (int i = 0; i < 5; i++) begin
            send_bit(1'b1, bits[4-i], p, s);
            got[19-4*i -: 4] = p;
        end
        total++;
        if (got !== 20'b1110_1000_1110_1110_1000) begin
            bad++;
            $display("FAIL R8 actual=%b expected=%b", got, 20'b11101000111011101000);
        end
    endtask

    task automatic t_ignore();
        logic [3:0] p, s;
        int n = 0;
        while (!in_ready && n < 8) begin @(negedge clk); n++; end
        in_valid = 1'b1; in_data = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 1'b1;
        for (int k = 0; k < 4; k++) begin
            p[3-k] = line_out;
            if (k < 3) begin
                check("R7 ready low mid-period", {7'd0, in_ready}, 8'd0);
                @(negedge clk);
            end
        end
        in_valid = 1'b0; in_data = 1'b0;
        check("R7 period unchanged", {4'd0, p}, 8'b1000);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            p[3-k] = line_out;
            if (k < 3) @(negedge clk);
        end
        check("R7 late bit not taken", {4'd0, p}, 8'b1000);
    endtask

    initial begin
        t_reset();
        t_ready_period();
        t_single(1'b0, "R3 zero pattern");
        t_single(1'b1, "R4 one pattern");
        t_idle();
        t_sequence();
        t_ignore();
        t_single(1'b1, "R4 one after ignore");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule